// File: doc/BRIEF.md
# Blocking/Posted Write Bus Bridge

This block sits between a local processor bus and a request/acknowledge link to a remote target. The remote target has one offset space, and the local bus reaches it through two address windows. The top address bit picks the window: 0 gives blocking semantics and 1 gives posted semantics. The bits below it form the target offset that goes onto the link.

A blocking write stalls the processor by holding `cpu_ready` low. The stall lasts until the target acknowledges the write. A posted write is taken into a single-entry buffer in the cycle it is presented, so the processor moves on at once while the link finishes the transfer. The `busy` output shows that a posted transfer is still outstanding. A read stalls until data comes back, whichever window it uses.

Any access that arrives while an earlier transfer is still open waits until that transfer completes, and is issued only after it. Accesses therefore reach the target in program order. A synchronous reset drops the open request and never replays it.

Top module: `twin_window_bridge`

## Requirements
- R1: After reset, `tgt_req` and `busy` are low, and `cpu_ready` is high while `cpu_sel` is low.
- R2: `cpu_addr[AW-1]` selects the window (0 = blocking, 1 = posted). The link carries `cpu_addr[AW-2:0]` as `tgt_addr`, together with `cpu_we` and `cpu_wdata`. A given offset reaches the same target address through either window.
- R3: A write through the blocking window, presented with no open transfer, keeps `cpu_ready` low. `cpu_ready` rises in the cycle `tgt_ack` is high, so the wait is the target latency plus one cycle.
- R4: A write through the posted window, presented with no open transfer, sees `cpu_ready` high in that same cycle. `busy` is high from the next cycle until the transfer is acknowledged.
- R5: An access presented while a transfer is open sees `cpu_ready` low until that transfer completes. It is issued to the link only after that.
- R6: A read from either window keeps `cpu_ready` low until `tgt_ack`. In that cycle `cpu_rdata` carries `tgt_rdata`.
- R7: A read presented after a posted write reaches the target after that write.
- R8: Once raised, `tgt_req` stays high and `tgt_addr`, `tgt_we` and `tgt_wdata` stay stable until `tgt_ack` is sampled high. `tgt_req` is low in the cycle after the acknowledge.
- R9: A synchronous reset during an open transfer drops `tgt_req` and `busy` in the next cycle, and the transfer is never reissued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_sel | input | 1 | Processor access strobe, held until ready is sampled high |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | AW | Local address; the top bit selects the window |
| cpu_wdata | input | DW | Write byte |
| cpu_ready | output | 1 | Access completes on an edge where it is high with cpu_sel |
| cpu_rdata | output | DW | Read data, valid while ready is high for a read |
| busy | output | 1 | A posted write is still outstanding |
| tgt_req | output | 1 | Link request |
| tgt_we | output | 1 | Link direction |
| tgt_addr | output | AW-1 | Target offset |
| tgt_wdata | output | DW | Link write byte |
| tgt_ack | input | 1 | Target completes the request |
| tgt_rdata | input | DW | Target read byte |

## Verification
The bench targets a blocking write to an offset that a posted write has just targeted through the other window. A bridge that skipped the collision stall would lose the first write or overwrite the buffer. It also runs a read straight after a posted write: a bridge that let the read pass the write would log the two at the target in the wrong order. Exact stall lengths against a target with random latency expose a bridge that releases a blocking write early or holds a posted one. A reset in the middle of a long transfer shows whether the request survives or is replayed.

// File: rtl/twin_window_bridge.sv
module twin_window_bridge #(
  parameter int AW = 9,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cpu_sel,
  input  logic          cpu_we,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  output logic          cpu_ready,
  output logic [DW-1:0] cpu_rdata,
  output logic          busy,
  output logic          tgt_req,
  output logic          tgt_we,
  output logic [AW-2:0] tgt_addr,
  output logic [DW-1:0] tgt_wdata,
  input  logic          tgt_ack,
  input  logic [DW-1:0] tgt_rdata
);
  localparam int OW = AW - 1;

  logic win_post;
  logic owner_q;

  assign win_post = cpu_addr[AW-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      tgt_req   <= 1'b0;
      owner_q   <= 1'b0;
      tgt_we    <= 1'b0;
      tgt_addr  <= '0;
      tgt_wdata <= '0;
    end else if (tgt_req) begin
      if (tgt_ack) begin
        tgt_req <= 1'b0;
        owner_q <= 1'b0;
      end
    end else if (cpu_sel) begin
      tgt_req   <= 1'b1;
      owner_q   <= !(cpu_we && win_post);
      tgt_we    <= cpu_we;
      tgt_addr  <= cpu_addr[OW-1:0];
      tgt_wdata <= cpu_wdata;
    end
  end

  assign cpu_ready = !cpu_sel || (tgt_req ? (owner_q && tgt_ack) : (cpu_we && win_post));
  assign cpu_rdata = tgt_rdata;
  assign busy      = tgt_req && !owner_q;

  a_r8_req_hold: assert property (@(posedge clk) disable iff (rst)
    (tgt_req && !tgt_ack) |=> (tgt_req && $stable(tgt_addr) && $stable(tgt_wdata) && $stable(tgt_we)));
  a_r8_req_drop: assert property (@(posedge clk) disable iff (rst)
    (tgt_req && tgt_ack) |=> !tgt_req);
  a_r5_stall_open: assert property (@(posedge clk) disable iff (rst)
    (cpu_sel && tgt_req && !tgt_ack) |-> !cpu_ready);
  a_r4_post_busy: assert property (@(posedge clk) disable iff (rst)
    (cpu_sel && cpu_we && win_post && !tgt_req) |=> busy);
  a_r6_read_stall: assert property (@(posedge clk) disable iff (rst)
    (cpu_sel && !cpu_we && !tgt_req) |-> !cpu_ready);
  a_r2_launch_addr: assert property (@(posedge clk) disable iff (rst)
    (cpu_sel && !tgt_req) |=> (tgt_req && tgt_addr == $past(cpu_addr[OW-1:0])));
  a_r9_reset_clear: assert property (@(posedge clk) rst |=> (!tgt_req && !busy));
endmodule

// File: tb/twin_window_bridge_test.sv
module twin_window_bridge_test;
  localparam int AW = 9, DW = 8, OW = 8;

  logic clk = 1'b0, rst = 1'b1;
  logic cpu_sel = 1'b0, cpu_we = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic [DW-1:0] cpu_wdata = '0;
  logic cpu_ready, busy, tgt_req, tgt_we;
  logic [DW-1:0] cpu_rdata, tgt_wdata;
  logic [OW-1:0] tgt_addr;
  logic tgt_ack = 1'b0;
  logic [DW-1:0] tgt_rdata = '0;

  always #4 clk = ~clk;

  twin_window_bridge #(.AW(AW), .DW(DW)) uut (
    .clk(clk), .rst(rst), .cpu_sel(cpu_sel), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata), .busy(busy),
    .tgt_req(tgt_req), .tgt_we(tgt_we), .tgt_addr(tgt_addr), .tgt_wdata(tgt_wdata),
    .tgt_ack(tgt_ack), .tgt_rdata(tgt_rdata));

  int total = 0, bad = 0, cycles = 0;
  int cnt = 0, cur_lat = 0, force_lat = -1;
  logic        lg_we [0:1023];
  logic [7:0]  lg_ad [0:1023];
  logic [7:0]  lg_d  [0:1023];
  int lg_n = 0;
  logic        ex_we [0:1023];
  logic [7:0]  ex_ad [0:1023];
  logic [7:0]  ex_d  [0:1023];
  int ex_n = 0;

  function automatic logic [7:0] rfun(input logic [7:0] a);
    return (a ^ 8'h5A) + 8'd3;
  endfunction

  task automatic chk(input bit ok, input string rq, input string what, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst || !tgt_req) begin
      tgt_ack = 1'b0;
      cnt = 0;
    end else if (tgt_ack) begin
      tgt_ack = 1'b0;
    end else if (cnt >= cur_lat) begin
      tgt_ack = 1'b1;
      tgt_rdata = rfun(tgt_addr);
      if (lg_n < 1024) begin
        lg_we[lg_n] = tgt_we; lg_ad[lg_n] = tgt_addr; lg_d[lg_n] = tgt_wdata;
      end
      lg_n++;
      cur_lat = (force_lat >= 0) ? force_lat : int'($urandom % 4);
      cnt = 0;
    end else begin
      cnt++;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic access(input bit we, input bit win, input logic [7:0] off, input logic [7:0] d,
                        output int waits, output logic [7:0] rd, output bit idle0, output int lat0);
    @(negedge clk);
    cpu_sel = 1'b1; cpu_we = we; cpu_addr = {win, off}; cpu_wdata = d; waits = 0;
    ex_we[ex_n] = we; ex_ad[ex_n] = off; ex_d[ex_n] = d; ex_n++;
    #2;
    idle0 = !tgt_req; lat0 = cur_lat;
    while (!cpu_ready) begin
      waits++;
      @(negedge clk); #2;
    end
    rd = cpu_rdata;
    @(posedge clk); #1;
    cpu_sel = 1'b0;
  endtask

  task automatic drain();
    while (tgt_req) @(negedge clk);
    @(negedge clk);
  endtask

  int w, l; logic [7:0] rd; bit idl; int saved;

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk); #2;
    chk(tgt_req == 0, "R1", "req after reset", tgt_req, 0);
    chk(busy == 0, "R1", "busy after reset", busy, 0);
    chk(cpu_ready == 1, "R1", "ready when idle", cpu_ready, 1);

    access(1, 1, 8'h3C, 8'h11, w, rd, idl, l);
    chk(w == 0, "R4", "posted write wait", w, 0);
    chk(busy == 1, "R4", "busy after posting", busy, 1);
    access(1, 0, 8'h3C, 8'h22, w, rd, idl, l);
    chk(w >= 1, "R5", "collision stall", w, 1);
    chk(tgt_req == 0, "R8", "req low after ack", tgt_req, 0);
    drain();
    chk(lg_n == 2 && lg_ad[0] == 8'h3C && lg_ad[1] == 8'h3C, "R2", "alias offsets", lg_ad[1], 8'h3C);
    chk(lg_d[0] == 8'h11 && lg_d[1] == 8'h22, "R5", "issue order data", lg_d[1], 8'h22);

    access(1, 1, 8'h81, 8'h9E, w, rd, idl, l);
    access(0, 1, 8'h81, 8'h00, w, rd, idl, l);
    chk(w >= 1, "R7", "read waits behind posted", w, 1);
    chk(rd == rfun(8'h81), "R6", "read data", rd, rfun(8'h81));
    chk(lg_we[2] == 1 && lg_we[3] == 0, "R7", "write before read", lg_we[3], 0);
    drain();

    for (int i = 0; i < 300; i++) begin
      bit we, win; logic [7:0] off, d;
      we = 1'($urandom); win = 1'($urandom); off = 8'($urandom); d = 8'($urandom);
      access(we, win, off, d, w, rd, idl, l);
      if (idl && we && win) chk(w == 0, "R4", "posted wait rnd", w, 0);
      else if (idl && we) chk(w == l + 1, "R3", "blocking wait rnd", w, l + 1);
      else if (idl) chk(w == l + 1, "R6", "read wait rnd", w, l + 1);
      else chk(w >= 1, "R5", "collision wait rnd", w, 1);
      if (!we) chk(rd == rfun(off), "R6", "read data rnd", rd, rfun(off));
      if (($urandom % 4) == 0) repeat ($urandom % 5) @(negedge clk);
    end
    drain();
    chk(lg_n == ex_n, "R7", "transfer count", lg_n, ex_n);
    for (int i = 0; i < ex_n && i < lg_n; i++) begin
      bit ok;
      ok = lg_we[i] == ex_we[i] && lg_ad[i] == ex_ad[i] && (!ex_we[i] || lg_d[i] == ex_d[i]);
      chk(ok, "R2", "logged transfer", lg_ad[i], ex_ad[i]);
    end

    force_lat = 20; cur_lat = 20;
    access(1, 1, 8'h47, 8'hC3, w, rd, idl, l);
    ex_n--;
    saved = lg_n;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); #2;
      chk(tgt_req && tgt_addr == 8'h47 && tgt_wdata == 8'hC3, "R8", "request held", tgt_addr, 8'h47);
    end
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0; #2;
    chk(tgt_req == 0, "R9", "req cleared", tgt_req, 0);
    chk(busy == 0, "R9", "busy cleared", busy, 0);
    force_lat = -1; cur_lat = 1;
    repeat (30) @(negedge clk);
    chk(lg_n == saved && tgt_req == 0, "R9", "no replay", lg_n, saved);
    access(1, 0, 8'h05, 8'h66, w, rd, idl, l);
    chk(w == 2, "R3", "blocking after reset", w, 2);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule